// File: doc/BRIEF.md
# Watchdog Timer with Reversed Reload Field

This block is a software-armed watchdog. One 8-bit register holds both the control bits and the reload value. An oscillator clock-enable input paces a two-stage prescaler. The first stage divides by 12 and the second by 256. Each prescaler tick decrements a 7-bit down-counter. Bit 6 of the counter is the reset-request bit. When that bit falls from 1 to 0, the block emits a system reset pulse.

Software arms the watchdog by writing the enable bit. It must then keep writing the register before the counter runs out. In the register, the six timeout bits appear in mirrored order compared with the counter. The enable bit is sticky. Writing the reset-request bit as 0 on an armed or arming write forces an immediate reset.

Top module: `rev_watchdog`

## Requirements
- R1: After `rst_n` is released, `rd_data` reads 0xFE and `sys_rst` is low. While `sys_rst` is high, `rd_data` reads 0xFE.
- R2: Register field positions are as follows. Bit 0 is the enable bit. Bit 1 is the reset-request bit, which is counter bit 6. Bits 7 down to 2 hold counter bits 0 up to 5, so bit 7 maps to counter bit 0 and bit 2 maps to counter bit 5. A write loads the counter through this mapping, and a read returns the live counter through the same mapping.
- R3: While the enable bit is 0, the counter and prescaler hold and `sys_rst` never rises, even when the reset-request bit has been written 0.
- R4: Take a write with the enable bit set, the reset-request bit 1, and timeout value N in counter bits 5..0. `sys_rst` rises exactly (N+1)*TICK oscillator cycles after that write, where TICK = PRE_A * 2^PRE_B_W (3,072 by default). The period therefore ranges from TICK at N=0 to 64*TICK at N=63.
- R5: A write with bit 1 = 0, made while enabled or with bit 0 = 1, raises `sys_rst` in the cycle after the write.
- R6: Once the enable bit is 1, a write with bit 0 = 0 leaves it at 1. Only a reset pulse or `rst_n` clears it.
- R7: Any write while enabled reloads the counter and restarts the prescaler. A write in the same cycle as the expiring tick wins, and no reset is produced.
- R8: `sys_rst` stays high for exactly PULSE_LEN oscillator cycles (4 by default). It then falls, with the register at 0xFE.
- R9: The prescaler and the pulse length count only cycles in which `osc_en` is high.
- R10: Between writes, the value read back decrements by one every TICK oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator cycle qualifier |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Live register view |
| sys_rst | output | 1 | Reset request pulse |

## Verification
Two functions can fall in the same clock edge: a software refresh write and the tick that would take the counter's bit 6 from 1 to 0. The bench provokes this by arming with N=0 and writing again exactly TICK oscillator cycles later. It judges the outcome by checking that no pulse appears and that the next expiry comes a full TICK after the second write. A reload in that cycle must win over the expiry.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int TBITS = 6;
  localparam int CW    = TBITS + 1;
  localparam logic [7:0] REG_RST = 8'hFE;

  // register image -> physical counter (timeout field mirrored, SR on top)
  function automatic logic [CW-1:0] reg_to_cnt(input logic [7:0] d);
    logic [CW-1:0] r;
    for (int i = 0; i < TBITS; i++) r[i] = d[7-i];
    r[TBITS] = d[1];
    return r;
  endfunction

  // physical counter + enable -> register image
  function automatic logic [7:0] cnt_to_reg(input logic [CW-1:0] c, input logic en);
    logic [7:0] r;
    for (int i = 0; i < TBITS; i++) r[7-i] = c[i];
    r[1] = c[TBITS];
    r[0] = en;
    return r;
  endfunction
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
  parameter int PRE_A   = 12,
  parameter int PRE_B_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic osc_en,
  output logic tick
);
  localparam int AW = (PRE_A > 1) ? $clog2(PRE_A) : 1;
  localparam logic [AW-1:0] A_LAST = AW'(PRE_A - 1);
  localparam logic [PRE_B_W-1:0] B_LAST = '1;

  logic [AW-1:0]      a_q;
  logic [PRE_B_W-1:0] b_q;
  logic               a_wrap;

  assign a_wrap = (a_q == A_LAST);
  assign tick   = run & osc_en & a_wrap & (b_q == B_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (clr) begin
      a_q <= '0;
      b_q <= '0;
    end else if (run && osc_en) begin
      if (a_wrap) begin
        a_q <= '0;
        b_q <= b_q + 1'b1;
      end else begin
        a_q <= a_q + 1'b1;
      end
    end
  end

  // R9: ticks are spaced, never back to back
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wd_downcount.sv
module wd_downcount
  import wd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          sr_fall
);
  localparam logic [CW-1:0] EDGE_VAL = CW'(1) << TBITS;

  logic [CW-1:0] cnt_q;
  assign cnt     = cnt_q;
  assign sr_fall = dec & ~load & (cnt_q == EDGE_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '1;
    else if (init)  cnt_q <= '1;
    else if (load)  cnt_q <= load_val;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
  end

  // R10: an unobstructed tick removes exactly one count
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && !init) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/wd_rstpulse.sv
module wd_rstpulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic osc_en,
  output logic pulse
);
  localparam int NW = $clog2(PULSE_LEN + 1);
  localparam logic [NW-1:0] N_LAST = NW'(PULSE_LEN - 1);

  logic [NW-1:0] n_q;
  logic          p_q;
  assign pulse = p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      n_q <= '0;
    end else if (!p_q) begin
      if (fire) begin
        p_q <= 1'b1;
        n_q <= '0;
      end
    end else if (osc_en) begin
      if (n_q == N_LAST) p_q <= 1'b0;
      else               n_q <= n_q + 1'b1;
    end
  end

  // R8: a started pulse lasts past its first cycle
  a_r8_pulse_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_q) |=> p_q);
  // R9: without an oscillator cycle the pulse cannot end
  a_r9_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (p_q && !osc_en) |=> p_q);
endmodule

// File: rtl/rev_watchdog.sv
module rev_watchdog
  import wd_pkg::*;
#(
  parameter int PRE_A     = 12,
  parameter int PRE_B_W   = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_rst
);
  logic          c_q;
  logic          pulse;
  logic          tick;
  logic          sr_fall;
  logic          wr_take;
  logic          sw_kill;
  logic          fire;
  logic          init;
  logic [CW-1:0] cnt;

  assign wr_take = wr_en & ~pulse;
  assign sw_kill = wr_take & ~wr_data[1] & (c_q | wr_data[0]);
  assign fire    = sr_fall | sw_kill;
  assign init    = fire | pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       c_q <= 1'b0;
    else if (init)    c_q <= 1'b0;
    else if (wr_take) c_q <= c_q | wr_data[0];
  end

  wd_prescaler #(.PRE_A(PRE_A), .PRE_B_W(PRE_B_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(wr_take | init), .run(c_q),
    .osc_en(osc_en), .tick(tick));

  wd_downcount u_cnt (
    .clk(clk), .rst_n(rst_n), .init(init), .load(wr_take),
    .load_val(reg_to_cnt(wr_data)), .dec(tick), .cnt(cnt), .sr_fall(sr_fall));

  wd_rstpulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst_n(rst_n), .fire(fire), .osc_en(osc_en), .pulse(pulse));

  assign rd_data = cnt_to_reg(cnt, c_q);
  assign sys_rst = pulse;

  // R1: register image is the reset value during the pulse
  a_r1_pulse_regval: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> rd_data == REG_RST);
  // R6: the enable bit only falls together with a reset pulse
  a_r6_c_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(c_q) |-> sys_rst);
  // R3: a disarmed watchdog stays quiet
  a_r3_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_q && !(wr_en && wr_data[0])) |=> !$rose(sys_rst));
  // R5: clearing the request bit on an armed write resets at once
  a_r5_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_rst && !wr_data[1] && (c_q || wr_data[0])) |=> $rose(sys_rst));
  // R4: the request bit falling starts the pulse
  a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
    sr_fall |=> $rose(sys_rst));
endmodule

// File: tb/rev_watchdog_bench.sv
module rev_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PA = 3;
  localparam int PBW = 2;
  localparam int TICK = PA * (1 << PBW);
  localparam int PLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b1;
  logic half = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sys_rst;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int n_osc;
  int n_clk;

  rev_watchdog #(.PRE_A(PA), .PRE_B_W(PBW), .PULSE_LEN(PLEN)) u_rev_watchdog (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sys_rst(sys_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) osc_en <= half ? ~osc_en : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  // count oscillator and clock edges from the last write until sys_rst rises
  task automatic measure();
    n_osc = 0;
    n_clk = 0;
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      n_clk++;
      if (osc_en) n_osc++;
      #1;
      if (sys_rst) break;
    end
  endtask

  // count oscillator edges while the pulse is held
  task automatic pulse_len();
    n_osc = 0;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (osc_en) n_osc++;
      #1;
      if (!sys_rst) break;
    end
  endtask

  task automatic t_reset();
    #1;
    chk(rd_data == 8'hFE, "R1 reset value", rd_data, 8'hFE);
    chk(sys_rst == 1'b0, "R1 reset output low", sys_rst, 0);
  endtask

  task automatic t_map_and_off();
    wr(8'h82);
    chk(rd_data == 8'h82, "R2 T0 at bit7", rd_data, 8'h82);
    wr(8'h06);
    chk(rd_data == 8'h06, "R2 T5 at bit2", rd_data, 8'h06);
    repeat (5 * TICK) @(posedge clk);
    #1;
    chk(rd_data == 8'h06 && !sys_rst, "R3 counter holds when off", rd_data, 8'h06);
    wr(8'h00);
    repeat (3 * TICK) @(posedge clk);
    #1;
    chk(sys_rst == 1'b0, "R3 SR=0 while off no reset", sys_rst, 0);
    chk(rd_data == 8'h00, "R3 SR=0 held while off", rd_data, 8'h00);
  endtask

  task automatic t_min_max();
    wr(8'h03);
    measure();
    chk(n_osc == TICK, "R4 min period", n_osc, TICK);
    chk(rd_data == 8'hFE, "R1 value during pulse", rd_data, 8'hFE);
    pulse_len();
    chk(n_osc == PLEN, "R8 pulse length", n_osc, PLEN);
    chk(rd_data == 8'hFE, "R8 register after pulse", rd_data, 8'hFE);
    wr(8'hFF);
    measure();
    chk(n_osc == 64 * TICK, "R4 max period", n_osc, 64 * TICK);
    pulse_len();
  endtask

  task automatic t_live_sticky();
    wr(8'hA3);
    repeat (TICK - 1) @(posedge clk);
    #1;
    chk(rd_data == 8'hA3, "R10 value before tick", rd_data, 8'hA3);
    @(posedge clk);
    #1;
    chk(rd_data == 8'h23, "R10 live decrement", rd_data, 8'h23);
    wr(8'hA2);
    chk(rd_data == 8'hA3, "R6 enable sticky", rd_data, 8'hA3);
    measure();
    chk(n_osc == 6 * TICK, "R7 reload restarts period", n_osc, 6 * TICK);
    pulse_len();
  endtask

  task automatic t_kill();
    wr(8'h03);
    wr(8'h01);
    chk(sys_rst == 1'b1, "R5 SR cleared while armed", sys_rst, 1);
    pulse_len();
    chk(rd_data == 8'hFE, "R1 register after kill", rd_data, 8'hFE);
    wr(8'h01);
    chk(sys_rst == 1'b1, "R5 SR cleared on arming write", sys_rst, 1);
    pulse_len();
  endtask

  task automatic t_collision();
    wr(8'h03);
    repeat (TICK - 1) @(posedge clk);
    wr(8'h03);
    chk(sys_rst == 1'b0, "R7 write beats expiring tick", sys_rst, 0);
    measure();
    chk(n_osc == TICK, "R7 period after colliding refresh", n_osc, TICK);
    pulse_len();
  endtask

  task automatic t_half_rate();
    half = 1'b1;
    wr(8'h43);
    measure();
    chk(n_osc == 3 * TICK, "R9 counts osc cycles only", n_osc, 3 * TICK);
    chk(n_clk >= 6 * TICK - 1, "R9 clock span at half rate", n_clk, 6 * TICK);
    pulse_len();
    chk(n_osc == PLEN, "R9 pulse in osc cycles", n_osc, PLEN);
    half = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_and_off();
    t_min_max();
    t_live_sticky();
    t_kill();
    t_collision();
    t_half_rate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule